// File: doc/BRIEF.md
# Masked Fuse Row Read Filter

This block serves 32-bit row reads from a one-time-programmable fuse array. Writing the read-address register starts a read. The block splits the written address into an array selector and a row index. It drives the matching physical row onto a simple combinational row-read port of the fuse storage and filters the returned word before it lands in a read-only data register.

Logical array 0 holds mixed-purpose rows, and each row has its own column permission mask. Some rows expose only a few columns and many rows are refused outright. Logical arrays 2 and 3 are helper-data arrays that sit on physical arrays 1 and 2, and they are returned unmasked. Logical array 1 is never readable.

Every read sets a done flag or an error flag. A refused read leaves zero in the data register. An interrupt line reflects the outcome flags gated by per-flag enables.

Top module: `fuse_rowrd_filter`

## Requirements
- R1: The address input is 8 bits wide. It carries bus address bits 12:5: bits 7:6 are the logical array and bits 5:0 the row. While a write is presented, the row port shows the written row, and the physical array output shows 0 for logical array 0, 1 for logical array 2 and 2 for logical array 3.
- R2: A granted read of logical array 0 returns the row word ANDed with that row's mask. The masks are: row 0 columns 28..31; rows 8..15 all columns; row 16 columns 0..7 and 10..16; row 17 columns 0..2; row 20 all columns; row 21 columns 0..23 and 29..31; rows 22 and 23 all columns; rows 40..63 all columns.
- R3: Every other row of logical array 0 (1..7, 18, 19, 24..39) is refused.
- R4: Reads of logical arrays 2 and 3 are granted and return the full row word of physical arrays 1 and 2.
- R5: Every read of logical array 1 is refused, whatever the row.
- R6: A granted read sets the done flag and clears the error flag. The two flags are never high together.
- R7: A refused read loads zero into the data register, sets the error flag and clears the done flag.
- R8: Data and flags take the new result on the clock edge that accepts the address write, so they are visible one cycle after the write is presented. Without a write they hold their values, and the data register has no write path.
- R9: The interrupt output equals (done AND enable bit 0) OR (error AND enable bit 1), and it follows enable changes at once.
- R10: Synchronous active-high reset clears the data register and both flags, so the interrupt is low whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_we_i | input | 1 | Write strobe for the read-address register; starts a read |
| rd_addr_i | input | 8 | Address bits 12:5: {logical array[1:0], row[5:0]} |
| fuse_arr_o | output | 2 | Physical array selected on the row-read port |
| fuse_row_o | output | 6 | Row selected on the row-read port |
| fuse_row_q_i | input | 32 | Row word returned by the fuse storage, same cycle |
| irq_en_i | input | 2 | Interrupt enables: bit 0 for done, bit 1 for error |
| rd_data_o | output | 32 | Read-data register, read-only |
| rd_done_o | output | 1 | Read-done status flag |
| rd_err_o | output | 1 | Read-error status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The fuse storage model returns a mostly-ones word that differs per physical array and row. A masked word therefore shows exactly which columns a row's mask lets through, and the physical-array term reveals a wrong array remap.

Array-0 rows are taken from each grant class: partial-mask rows, full rows, and the first and last rows of each span. They are mixed with refused rows that sit right next to granted ones (1, 7, 18, 19, 24, 39), so an off-by-one in a range boundary shows up. Array-1, array-2 and array-3 reads, back-to-back reads that alternate grant and refusal, idle stretches and all four enable settings separate the flag update, the hold behaviour and the interrupt gating.

// File: rtl/frf_pkg.sv
package frf_pkg;

    localparam int COL_W  = 32;
    localparam int ROW_W  = 6;
    localparam int SEL_W  = 2;
    localparam int ADDR_W = SEL_W + ROW_W;

    typedef logic [COL_W-1:0] row_word_t;
    typedef logic [ROW_W-1:0] row_idx_t;
    typedef logic [SEL_W-1:0] arr_sel_t;

    // Decoded request: physical target, row, and grant class.
    typedef struct packed {
        arr_sel_t phys;
        row_idx_t row;
        logic     grant;
        logic     full;
    } rd_req_t;

    // Filtered result heading into the output register.
    typedef struct packed {
        row_word_t data;
        logic      done;
        logic      err;
    } rd_res_t;

    function automatic row_word_t span(input int lo, input int hi);
        row_word_t m;
        for (int i = 0; i < COL_W; i++) begin
            m[i] = (i >= lo) && (i <= hi);
        end
        return m;
    endfunction

    // Column permission of a row in logical array 0; zero means refused.
    function automatic row_word_t col_perm(input row_idx_t row);
        row_word_t m;
        m = '0;
        if (row == 6'd0)                      m = span(28, 31);
        else if (row >= 6'd8  && row <= 6'd15) m = '1;
        else if (row == 6'd16)                 m = span(0, 7) | span(10, 16);
        else if (row == 6'd17)                 m = span(0, 2);
        else if (row == 6'd20)                 m = '1;
        else if (row == 6'd21)                 m = span(0, 23) | span(29, 31);
        else if (row == 6'd22 || row == 6'd23) m = '1;
        else if (row >= 6'd40)                 m = '1;
        return m;
    endfunction

endpackage

// File: rtl/frf_decode.sv
module frf_decode
    import frf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output rd_req_t           req_o
);
    arr_sel_t log_arr;
    row_idx_t row;

    assign log_arr = addr_i[ADDR_W-1 -: SEL_W];
    assign row     = addr_i[ROW_W-1:0];

    always_comb begin
        req_o.row   = row;
        req_o.phys  = '0;
        req_o.grant = 1'b0;
        req_o.full  = 1'b0;
        unique case (log_arr)
            2'd0: begin
                req_o.grant = |col_perm(row);
            end
            2'd1: begin
                req_o.grant = 1'b0;
            end
            default: begin
                // Logical 2/3 skip the hidden array 1 slot.
                req_o.phys  = log_arr - arr_sel_t'(1);
                req_o.grant = 1'b1;
                req_o.full  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/frf_mask.sv
module frf_mask
    import frf_pkg::*;
(
    input  rd_req_t   req_i,
    input  row_word_t row_q_i,
    output rd_res_t   res_o
);
    row_word_t mask;

    assign mask = req_i.full ? '1 : col_perm(req_i.row);

    always_comb begin
        res_o.data = req_i.grant ? (row_q_i & mask) : '0;
        res_o.done = req_i.grant;
        res_o.err  = ~req_i.grant;
    end
endmodule

// File: rtl/frf_result.sv
module frf_result
    import frf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  rd_res_t res_i,
    output rd_res_t res_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q_o <= '0;
        end else if (load_i) begin
            res_q_o <= res_i;
        end
    end
endmodule

// File: rtl/fuse_rowrd_filter.sv
module fuse_rowrd_filter
    import frf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_addr_we_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [SEL_W-1:0]  fuse_arr_o,
    output logic [ROW_W-1:0]  fuse_row_o,
    input  logic [COL_W-1:0]  fuse_row_q_i,
    input  logic [1:0]        irq_en_i,
    output logic [COL_W-1:0]  rd_data_o,
    output logic              rd_done_o,
    output logic              rd_err_o,
    output logic              irq_o
);
    rd_req_t req;
    rd_res_t res_d;
    rd_res_t res_q;

    frf_decode u_decode (
        .addr_i (rd_addr_i),
        .req_o  (req)
    );

    assign fuse_arr_o = req.phys;
    assign fuse_row_o = req.row;

    frf_mask u_mask (
        .req_i   (req),
        .row_q_i (fuse_row_q_i),
        .res_o   (res_d)
    );

    frf_result u_result (
        .clk     (clk),
        .rst     (rst),
        .load_i  (rd_addr_we_i),
        .res_i   (res_d),
        .res_q_o (res_q)
    );

    assign rd_data_o = res_q.data;
    assign rd_done_o = res_q.done;
    assign rd_err_o  = res_q.err;
    assign irq_o     = (res_q.done & irq_en_i[0]) | (res_q.err & irq_en_i[1]);
endmodule

// File: rtl/frf_chk.sv
module frf_chk (
    input logic        clk,
    input logic        rst,
    input logic        we,
    input logic [7:0]  addr,
    input logic [1:0]  arr,
    input logic [31:0] row_q,
    input logic [31:0] data,
    input logic        done,
    input logic        err
);
    assert_arr1_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (we && addr[7:6] == 2'd1) |=> (err && !done && data == 32'h0));

    assert_helper_full_R4: assert property (@(posedge clk) disable iff (rst)
        (we && addr[7]) |=> (done && !err && data == $past(row_q)));

    assert_helper_remap_R1: assert property (@(posedge clk) disable iff (rst)
        (we && addr[7]) |-> (arr == addr[7:6] - 2'd1));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(data) && $stable(done) && $stable(err)));

    assert_row0_cols_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 8'h00) |=> (data[27:0] == 28'h0));

    assert_gap_row_refused_R3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 8'h01) |=> (err && data == 32'h0));
endmodule

bind fuse_rowrd_filter frf_chk u_frf_chk (
    .clk   (clk),
    .rst   (rst),
    .we    (rd_addr_we_i),
    .addr  (rd_addr_i),
    .arr   (fuse_arr_o),
    .row_q (fuse_row_q_i),
    .data  (rd_data_o),
    .done  (rd_done_o),
    .err   (rd_err_o)
);

// File: tb/fuse_rowrd_filter_tb.sv
`timescale 1ns/1ps
module fuse_rowrd_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  farr;
    logic [5:0]  frow;
    logic [31:0] fq;
    logic [1:0]  en = 2'b00;
    logic [31:0] rdata;
    logic        rdone, rerr, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fuse_rowrd_filter dut_i (
        .clk          (clk),
        .rst          (rst),
        .rd_addr_we_i (we),
        .rd_addr_i    (addr),
        .fuse_arr_o   (farr),
        .fuse_row_o   (frow),
        .fuse_row_q_i (fq),
        .irq_en_i     (en),
        .rd_data_o    (rdata),
        .rd_done_o    (rdone),
        .rd_err_o     (rerr),
        .irq_o        (irq)
    );

    function automatic logic [31:0] pat(input logic [1:0] pa, input logic [5:0] r);
        return 32'hFFFF_FFFF ^ (32'(r) << 8) ^ (32'(pa) << 16) ^ 32'(r);
    endfunction

    always_comb fq = pat(farr, frow);

    function automatic logic [31:0] exp_mask(input logic [5:0] r);
        if (r == 0) return 32'hF000_0000;
        if (r >= 8 && r <= 15) return 32'hFFFF_FFFF;
        if (r == 16) return 32'h0001_FCFF;
        if (r == 17) return 32'h0000_0007;
        if (r == 20 || r == 22 || r == 23) return 32'hFFFF_FFFF;
        if (r == 21) return 32'hE0FF_FFFF;
        if (r >= 40) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    typedef struct {
        logic [31:0] d;
        logic        done;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [5:0] r, input string tag);
        exp_t e;
        logic [31:0] m;
        logic [1:0]  pa;
        pa = (a == 2'd0) ? 2'd0 : (a - 2'd1);
        if (a == 2'd0) begin
            m = exp_mask(r);
            e.done = (m != 0);
            e.d = pat(2'd0, r) & m;
        end else if (a == 2'd1) begin
            e.done = 1'b0;
            e.d = 32'h0;
        end else begin
            e.done = 1'b1;
            e.d = pat(pa, r);
        end
        e.err = ~e.done;
        e.tag = tag;
        @(negedge clk);
        we = 1'b1;
        addr = {a, r};
        sb.push_back(e);
        #1;
        chk(frow == r, "R1 row port", 32'(frow), 32'(r));
        if (a != 2'd1) chk(farr == pa, "R1 physical array", 32'(farr), 32'(pa));
    endtask

    task automatic idle(input int n);
        logic [31:0] d0;
        logic        f0, e0;
        @(negedge clk);
        we = 1'b0;
        addr = 8'h41;
        @(negedge clk);
        d0 = rdata; f0 = rdone; e0 = rerr;
        repeat (n) @(negedge clk);
        chk(rdata == d0, "R8 hold data without write", rdata, d0);
        chk({rdone, rerr} == {f0, e0}, "R8 hold flags without write",
            32'({rdone, rerr}), 32'({f0, e0}));
    endtask

    // Monitor: each accepted write produces a result one edge later.
    initial begin
        exp_t e;
        logic xi;
        forever begin
            @(posedge clk);
            if (we && !rst) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", 0, 0);
                end else begin
                    e = sb.pop_front();
                    chk(rdata == e.d, {e.tag, " data"}, rdata, e.d);
                    chk(rdone == e.done, {e.tag, " done R6"}, 32'(rdone), 32'(e.done));
                    chk(rerr == e.err, {e.tag, " error R7"}, 32'(rerr), 32'(e.err));
                    xi = (e.done & en[0]) | (e.err & en[1]);
                    chk(irq == xi, {e.tag, " irq R9"}, 32'(irq), 32'(xi));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        en = 2'b11;
        repeat (3) @(negedge clk);
        chk(rdata == 0, "R10 reset data", rdata, 0);
        chk({rdone, rerr, irq} == 3'b000, "R10 reset flags and irq",
            32'({rdone, rerr, irq}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R10 irq after reset", 32'(irq), 0);

        // R2: granted rows of array 0
        rd(2'd0, 6'd0,  "R2 row0");
        rd(2'd0, 6'd8,  "R2 row8");
        rd(2'd0, 6'd15, "R2 row15");
        rd(2'd0, 6'd16, "R2 row16");
        rd(2'd0, 6'd17, "R2 row17");
        rd(2'd0, 6'd20, "R2 row20");
        rd(2'd0, 6'd21, "R2 row21");
        rd(2'd0, 6'd22, "R2 row22");
        rd(2'd0, 6'd23, "R2 row23");
        rd(2'd0, 6'd40, "R2 row40");
        rd(2'd0, 6'd63, "R2 row63");
        idle(3);

        // R3: refused rows next to granted ones, alternating with grants
        en = 2'b10;
        rd(2'd0, 6'd1,  "R3 row1");
        rd(2'd0, 6'd8,  "R2 row8 after refusal");
        rd(2'd0, 6'd7,  "R3 row7");
        rd(2'd0, 6'd18, "R3 row18");
        rd(2'd0, 6'd19, "R3 row19");
        rd(2'd0, 6'd24, "R3 row24");
        rd(2'd0, 6'd39, "R3 row39");
        idle(2);

        // R5 and R4: other arrays
        en = 2'b01;
        rd(2'd1, 6'd8,  "R5 array1 row8");
        rd(2'd1, 6'd63, "R5 array1 row63");
        rd(2'd2, 6'd5,  "R4 array2 row5");
        rd(2'd3, 6'd63, "R4 array3 row63");
        rd(2'd2, 6'd1,  "R4 array2 row1");
        idle(2);

        // R9: enable gating follows enable changes at once
        en = 2'b00;
        rd(2'd3, 6'd0, "R9 en00 grant");
        rd(2'd1, 6'd0, "R9 en00 refuse");
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        en = 2'b10;
        #1;
        chk(irq == 1'b1, "R9 error enabled after refusal", 32'(irq), 1);
        en = 2'b01;
        #1;
        chk(irq == 1'b0, "R9 done-only enable after refusal", 32'(irq), 0);
        idle(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule